// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block collects the interrupt lines that belong to a four-core cluster and turns them into one level-sensitive interrupt output per core. Each core owns four private timer lines, which pass only where that core's own enable register allows them, and four private mailbox lines, which pass unmasked. One performance-monitor line is shared: it is delivered to any subset of cores through a routing mask that is changed by separate set and clear registers. One shared peripheral line is steered to exactly one core, chosen by a 2-bit routing field.

Every source that reaches a core is shown in that core's pending word, at a fixed bit position. The core's interrupt output is high while its pending word is non-zero. Software reaches all of this through a single-cycle register port. A write takes effect at the next clock edge. A read returns its data one cycle later, marked by a valid strobe. The port has no back-pressure: a read can be issued every cycle and its result is always delivered in the following cycle.

Top module: `lir_router`

## Requirements
- R1: After reset every register reads zero, every `core_irq` bit is low, and the shared peripheral line is routed to core 0.
- R2: The timer enable register of core c is at byte address 4·c (c = 0..3). Bits [3:0] enable timer lines `tmr_irq[4c+0..4c+3]` (secure physical, non-secure physical, hypervisor, virtual). Only an enabled line sets the matching bit [3:0] of that core's pending word.
- R3: Performance-monitor routing is a 4-bit core mask. A write to 0x10 sets the mask bits where the write data has a 1, and a write to 0x14 clears the mask bits where the write data has a 1. Zero bits leave the mask unchanged. Both addresses read back the mask in bits [3:0].
- R4: The routing register at 0x18 holds a core number in bits [1:0]. `shr_irq` reaches the pending word of that core only, so that at most one core, and exactly one while the line is high, sees it.
- R5: The pending word of core c is read at 0x20 + 4·c. Its layout is: bits [3:0] timers, bits [7:4] mailboxes, bit 8 the shared peripheral line, bit 9 the performance-monitor line. Bits [31:10] read zero.
- R6: The mailbox lines `mbx_irq[4c+3:4c]` appear unmasked in bits [7:4] of core c's pending word.
- R7: `core_irq[c]` is the OR of core c's pending word. It is level-sensitive, stays high while any routed source stays high, and falls once every routed source is removed or unrouted.
- R8: Reads, including reads of pending words, change no register and no output.
- R9: `reg_rvalid` is high exactly in the cycle after a cycle with `reg_re` high, and `reg_rdata` then holds the addressed value. A register write is visible from the cycle after the write.
- R10: Write data bits above a register's field are ignored. Writes to a pending word, to an unmapped address, or to an address with bits [1:0] not zero change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_re` |
| tmr_irq | input | 16 | Timer lines, four per core |
| mbx_irq | input | 16 | Mailbox lines, four per core |
| shr_irq | input | 1 | Shared peripheral interrupt line |
| pmu_irq | input | 1 | Performance-monitor interrupt line |
| core_irq | output | 4 | Interrupt output per core |

## Verification
Each result of this block is due at a known cycle:
- Read data appears at the edge after the `reg_re` cycle.
- A register write changes routing from the edge that samples it.
- `core_irq` follows the source lines within the same cycle, through logic only.

The bench drives on the falling edge and samples on the next falling edge. For a read, the driver pushes the expected word into a queue at the moment it raises `reg_re`. The monitor then requires `reg_rvalid` in exactly the following cycle and pops the word there. Interrupt outputs are compared with a model half a cycle after each write or source change has settled.

// File: rtl/lir_pkg.sv
package lir_pkg;
  localparam int unsigned NTMR    = 4;
  localparam int unsigned NMBX    = 4;
  localparam int unsigned BIT_MBX = NTMR;
  localparam int unsigned BIT_SHR = NTMR + NMBX;
  localparam int unsigned BIT_PMU = BIT_SHR + 1;
  localparam int unsigned PW      = BIT_PMU + 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TMR,
    SEL_PSET,
    SEL_PCLR,
    SEL_ROUTE,
    SEL_PEND
  } sel_e;
endpackage

// File: rtl/lir_decode.sv
module lir_decode
  import lir_pkg::*;
#(
  parameter int unsigned NCORE = 4,
  parameter int unsigned AW    = 8,
  parameter int unsigned CW    = 2
) (
  input  logic [AW-1:0] addr,
  output sel_e          sel,
  output logic [CW-1:0] idx
);
  localparam int unsigned WA = AW - 2;
  localparam logic [WA-1:0] W_TEND  = WA'(NCORE);
  localparam logic [WA-1:0] W_PSET  = WA'(NCORE);
  localparam logic [WA-1:0] W_PCLR  = WA'(NCORE + 1);
  localparam logic [WA-1:0] W_ROUTE = WA'(NCORE + 2);
  localparam logic [WA-1:0] W_PEND  = WA'(NCORE + 4);
  localparam logic [WA-1:0] W_PEND_E = WA'(2 * NCORE + 4);

  logic [WA-1:0] w;
  logic          aligned;

  assign w       = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (aligned) begin
      if (w < W_TEND) begin
        sel = SEL_TMR;
        idx = CW'(w);
      end else if (w == W_PSET) begin
        sel = SEL_PSET;
      end else if (w == W_PCLR) begin
        sel = SEL_PCLR;
      end else if (w == W_ROUTE) begin
        sel = SEL_ROUTE;
      end else if (w >= W_PEND && w < W_PEND_E) begin
        sel = SEL_PEND;
        idx = CW'(w - W_PEND);
      end
    end
  end
endmodule

// File: rtl/lir_regs.sv
module lir_regs
  import lir_pkg::*;
#(
  parameter int unsigned NCORE = 4,
  parameter int unsigned CW    = 2,
  parameter int unsigned DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  sel_e                  sel,
  input  logic [CW-1:0]         idx,
  input  logic [DW-1:0]         wdata,
  output logic [NCORE*NTMR-1:0] tmr_en,
  output logic [NCORE-1:0]      pmu_mask,
  output logic [CW-1:0]         route
);
  logic [NCORE-1:0][NTMR-1:0] en_q;
  logic [NCORE-1:0]           mask_q;
  logic [CW-1:0]              route_q;
  logic                       unused_wd;

  assign unused_wd = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= '0;
      route_q <= '0;
    end else if (we) begin
      case (sel)
        SEL_TMR:   en_q[idx] <= wdata[NTMR-1:0];
        SEL_PSET:  mask_q    <= mask_q | wdata[NCORE-1:0];
        SEL_PCLR:  mask_q    <= mask_q & ~wdata[NCORE-1:0];
        SEL_ROUTE: route_q   <= wdata[CW-1:0];
        default:   ;
      endcase
    end
  end

  assign tmr_en   = en_q;
  assign pmu_mask = mask_q;
  assign route    = route_q;

  for (genvar c = 0; c < NCORE; c++) begin : g_chk
    // R2: a timer enable write lands in that core's register only
    p_tmr_wr_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_TMR && idx == CW'(c)) |=> en_q[c] == $past(wdata[NTMR-1:0]));

    p_pmu_set_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_PSET && wdata[c]) |=> mask_q[c]);

    p_pmu_clr_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_PCLR && wdata[c]) |=> !mask_q[c]);

    p_pmu_keep_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (sel == SEL_PSET || sel == SEL_PCLR) && wdata[c])
        |=> mask_q[c] == $past(mask_q[c]));
  end

  p_route_wr_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_ROUTE) |=> route_q == $past(wdata[CW-1:0]));
endmodule

// File: rtl/lir_pend_core.sv
module lir_pend_core
  import lir_pkg::*;
#(
  parameter int unsigned CW   = 2,
  parameter int unsigned CORE = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTMR-1:0] tmr_irq,
  input  logic [NTMR-1:0] tmr_en,
  input  logic [NMBX-1:0] mbx_irq,
  input  logic            shr_irq,
  input  logic [CW-1:0]   route,
  input  logic            pmu_irq,
  input  logic            pmu_sel,
  output logic [PW-1:0]   pend,
  output logic            irq
);
  logic shr_hit;

  assign shr_hit = shr_irq && (route == CW'(CORE));

  always_comb begin
    pend                       = '0;
    pend[NTMR-1:0]             = tmr_irq & tmr_en;
    pend[BIT_MBX +: NMBX]      = mbx_irq;
    pend[BIT_SHR]              = shr_hit;
    pend[BIT_PMU]              = pmu_irq && pmu_sel;
  end

  assign irq = |pend;

  // R4: the shared line never shows on a core it is not steered to
  p_shr_excl_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (route != CW'(CORE)) |-> !pend[BIT_SHR]);

  // R2: a disabled timer line never reaches the pending word
  for (genvar t = 0; t < NTMR; t++) begin : g_tchk
    p_tmr_mask_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_en[t] |-> !pend[t]);
  end
endmodule

// File: rtl/lir_router.sv
module lir_router
  import lir_pkg::*;
#(
  parameter int unsigned NCORE = 4,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic                  reg_re,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  output logic                  reg_rvalid,
  input  logic [NCORE*NTMR-1:0] tmr_irq,
  input  logic [NCORE*NMBX-1:0] mbx_irq,
  input  logic                  shr_irq,
  input  logic                  pmu_irq,
  output logic [NCORE-1:0]      core_irq
);
  localparam int unsigned CW = (NCORE > 1) ? $clog2(NCORE) : 1;

  sel_e                       sel;
  logic [CW-1:0]              idx;
  logic [NCORE*NTMR-1:0]      tmr_en;
  logic [NCORE-1:0][NTMR-1:0] en2;
  logic [NCORE-1:0]           pmu_mask;
  logic [CW-1:0]              route;
  logic [NCORE-1:0][PW-1:0]   pend_all;
  logic [NCORE-1:0]           shr_bits;
  logic [DW-1:0]              rd_mux;
  logic [DW-1:0]              rdata_q;
  logic                       rvalid_q;

  lir_decode #(.NCORE(NCORE), .AW(AW), .CW(CW)) u_dec (
    .addr (reg_addr),
    .sel  (sel),
    .idx  (idx)
  );

  lir_regs #(.NCORE(NCORE), .CW(CW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .sel      (sel),
    .idx      (idx),
    .wdata    (reg_wdata),
    .tmr_en   (tmr_en),
    .pmu_mask (pmu_mask),
    .route    (route)
  );

  assign en2 = tmr_en;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    lir_pend_core #(.CW(CW), .CORE(c)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .tmr_irq (tmr_irq[c*NTMR +: NTMR]),
      .tmr_en  (en2[c]),
      .mbx_irq (mbx_irq[c*NMBX +: NMBX]),
      .shr_irq (shr_irq),
      .route   (route),
      .pmu_irq (pmu_irq),
      .pmu_sel (pmu_mask[c]),
      .pend    (pend_all[c]),
      .irq     (core_irq[c])
    );
    assign shr_bits[c] = pend_all[c][BIT_SHR];
  end

  always_comb begin
    case (sel)
      SEL_TMR:   rd_mux = DW'(en2[idx]);
      SEL_PSET,
      SEL_PCLR:  rd_mux = DW'(pmu_mask);
      SEL_ROUTE: rd_mux = DW'(route);
      SEL_PEND:  rd_mux = DW'(pend_all[idx]);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_re;
      if (reg_re) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;

  p_shr_onehot_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(shr_bits));

  p_shr_deliver_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    shr_irq |-> $countones(shr_bits) == 1);

  p_quiet_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_irq == '0 && mbx_irq == '0 && !shr_irq && !pmu_irq) |-> core_irq == '0);

  p_rd_pure_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && !reg_we) |=> $stable(tmr_en) && $stable(pmu_mask) && $stable(route));

  p_rvalid_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid == $past(reg_re));

  p_pend_hi_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && sel == SEL_PEND) |=> reg_rdata[DW-1:PW] == '0);
endmodule

// File: tb/lir_router_bench.sv
module lir_router_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [15:0] tmr_irq = '0;
  logic [15:0] mbx_irq = '0;
  logic        shr_irq = 1'b0;
  logic        pmu_irq = 1'b0;
  logic [3:0]  core_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic re_last = 1'b0;

  logic [3:0] m_en [4];
  logic [3:0] m_mask = '0;
  logic [1:0] m_route = '0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  lir_router u_lir_router (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .tmr_irq(tmr_irq), .mbx_irq(mbx_irq),
    .shr_irq(shr_irq), .pmu_irq(pmu_irq), .core_irq(core_irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pend(input int c);
    logic [31:0] v;
    v = '0;
    v[3:0] = tmr_irq[c*4 +: 4] & m_en[c];
    v[7:4] = mbx_irq[c*4 +: 4];
    v[8]   = shr_irq && (m_route == 2'(c));
    v[9]   = pmu_irq && m_mask[c];
    return v;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    for (int c = 0; c < 4; c++) v[c] = (exp_pend(c) != 0);
    return v;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (a[1:0] == 2'b00) begin
      if (a < 8'h10)       m_en[a[3:2]] = d[3:0];
      else if (a == 8'h10) m_mask = m_mask | d[3:0];
      else if (a == 8'h14) m_mask = m_mask & ~d[3:0];
      else if (a == 8'h18) m_route = d[1:0];
    end
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic rd_pend(input int c, input string tag);
    rd(8'(8'h20 + 4*c), exp_pend(c), tag);
  endtask

  task automatic chk_irq(input string tag);
    @(negedge clk);
    chk({28'b0, core_irq}, {28'b0, exp_irq()}, tag);
  endtask

  // rvalid must follow reg_re by exactly one cycle (R9)
  always @(posedge clk) re_last <= rst_n ? reg_re : 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_rvalid !== re_last) begin
        checks++; fails++;
        $display("FAIL R9 rvalid actual=%b expected=%b", reg_rvalid, re_last);
      end
      if (reg_rvalid) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9 unexpected read data actual=%h expected=none", reg_rdata);
        end else begin
          chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) m_en[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk_irq("R1 core_irq after reset");
    for (int c = 0; c < 4; c++) rd(8'(4*c), 32'h0, "R1 timer enable reset");
    rd(8'h10, 32'h0, "R1 pmu mask reset");
    rd(8'h18, 32'h0, "R1 route reset");
    for (int c = 0; c < 4; c++) rd_pend(c, "R1 pending reset");

    // R2 / R10: timer enables, upper bits ignored
    tmr_irq = 16'hFFFF;
    chk_irq("R2 timers disabled give no irq");
    wr(8'h08, 32'hFFFF_FFF5);
    rd(8'h08, 32'h5, "R10 timer enable upper bits ignored");
    rd(8'h00, 32'h0, "R2 other core untouched");
    wr(8'h04, 32'h8);
    rd_pend(2, "R2 core2 pending timers");
    rd_pend(1, "R2 core1 virtual timer bit3");
    rd_pend(0, "R2 core0 no timers");
    chk_irq("R7 irq from timers");
    tmr_irq = 16'h0F00 & ~16'h0400;
    chk_irq("R7 irq follows timer line");
    rd_pend(2, "R2 core2 partial timer");

    // R6: mailbox lines
    tmr_irq = '0;
    mbx_irq = 16'h00A0;
    chk_irq("R6 mailbox raises irq");
    rd_pend(1, "R6 mailbox in bits 7:4");
    rd_pend(3, "R6 other core no mailbox");
    mbx_irq = '0;
    chk_irq("R7 irq falls when mailbox drops");

    // R4 / R10: shared routing
    shr_irq = 1'b1;
    chk_irq("R4 shared goes to core0 by default");
    rd_pend(0, "R4 core0 shared bit8");
    wr(8'h18, 32'h7);
    rd(8'h18, 32'h3, "R10 route upper bits ignored");
    rd_pend(3, "R4 core3 shared bit8");
    rd_pend(0, "R4 core0 no shared after reroute");
    chk_irq("R4 only core3 interrupted");
    wr(8'h18, 32'h1);
    chk_irq("R4 route to core1");
    shr_irq = 1'b0;

    // R3: pmu set/clear
    pmu_irq = 1'b1;
    chk_irq("R3 pmu unrouted");
    wr(8'h10, 32'h3);
    rd(8'h10, 32'h3, "R3 set mask");
    wr(8'h10, 32'h8);
    rd(8'h14, 32'hB, "R3 set keeps zero bits");
    wr(8'h14, 32'h1);
    rd(8'h10, 32'hA, "R3 clear one bit");
    wr(8'h14, 32'h0);
    rd(8'h14, 32'hA, "R3 clear zero no change");
    rd_pend(3, "R5 core3 pmu bit9");
    rd_pend(0, "R5 core0 no pmu");
    chk_irq("R7 pmu irq cores 1 and 3");

    // R5: full layout on one core
    wr(8'h04, 32'hF);
    tmr_irq = 16'h0030;
    mbx_irq = 16'h0050;
    shr_irq = 1'b1;
    rd_pend(1, "R5 pending layout all fields");

    // R8: reads have no side effects
    rd_pend(1, "R8 repeat read same");
    rd(8'h18, 32'h1, "R8 route unchanged by reads");
    chk_irq("R8 irq unchanged by reads");

    // R10: writes to pending, unmapped, misaligned ignored
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h19, 32'h2);
    wr(8'h11, 32'h1);
    rd(8'h18, 32'h1, "R10 route after ignored writes");
    rd(8'h10, 32'hA, "R10 mask after ignored writes");
    rd_pend(1, "R10 pending after write attempt");

    // R9: back-to-back reads
    @(negedge clk);
    reg_re = 1'b1; reg_addr = 8'h04;
    exp_q.push_back(32'hF); tag_q.push_back("R9 back-to-back first");
    @(negedge clk);
    reg_addr = 8'h08;
    exp_q.push_back(32'h5); tag_q.push_back("R9 back-to-back second");
    @(negedge clk);
    reg_re = 1'b0;

    // R7: drop all sources
    tmr_irq = '0; mbx_irq = '0; shr_irq = 1'b0; pmu_irq = 1'b0;
    chk_irq("R7 all low without sources");

    repeat (3) @(negedge clk);
    chk(32'(exp_q.size()), 32'h0, "R9 all reads answered");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule